// File: doc/BRIEF.md
# Burst Request Decoder and Sub-Burst Splitter

This block takes one compact transfer request from a requester and turns it into a series of sub-bursts for a HyperBus-style memory controller. A request word either describes a fixed-length transfer, given as a block count and a power-of-two block size, or uses an escape code. The escape code means a variable-length transfer whose start address and byte length arrive on two side inputs. A fixed-length transfer starts at the address on the request address input.

The total byte count is split into sub-bursts. Each sub-burst is sized so that its data phase fits inside the chip-select time budget. That budget is the maximum chip-select-low time (short or long, as the refresh setting selects) minus a fixed setup, address and latency overhead, converted to bytes at the programmed bus clock. Sub-bursts go out one at a time, each with a start address and a byte count. The block waits for a completion strobe on each one, keeps a minimum chip-select-high gap between them, and keeps the transfer until all of it is done. A single-cycle completion pulse closes the request.

Top module: `req_split_top`

## Requirements
- R1: During and right after reset, `reqReady` is 1, and `burstValid` and `reqDone` are 0.
- R2: The block-size code is `reqWord[23:20]` and the block count is `reqWord[31:24]`. For a code other than 15, the total is count shifted left by the code, and the transfer starts at `reqAddr`.
- R3: A block count of 0 in a fixed-length request stands for 256 blocks.
- R4: A block-size code of 15 selects a variable-length transfer of `extLen` bytes that starts at `extAddr`. The count byte is then ignored.
- R5: A variable-length request with `extLen` of 0 issues no sub-burst. `reqDone` is high in the cycle after acceptance.
- R6: Each sub-burst length is min(budget, remaining bytes). The budget is (W·`cfgBusMhz` − 50)·2 bytes, where W is 4 when `cfgLongRefresh`=0 and 8 when it is 1. When W·`cfgBusMhz` ≤ 50, the budget is 2 bytes.
- R7: Each sub-burst starts at the previous start address plus the previous length.
- R8: `burstValid` first rises two cycles after the accepting edge. `burstValid`, `burstAddr` and `burstLen` then hold until `burstDone` is sampled high, and `burstValid` falls at that edge.
- R9: Between two sub-bursts of one transfer, `burstValid` stays low for exactly GAP_CLKS+1 cycles (4 by default).
- R10: `reqDone` is a one-cycle pulse in the cycle after the final `burstDone`. `reqReady` is high only when the block is idle, so it stays low through all sub-bursts of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBusMhz | input | 8 | Bus clock in MHz, used for the byte budget |
| cfgLongRefresh | input | 1 | 1 selects the long chip-select window |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Idle, request accepted when both are high |
| reqWord | input | 32 | Encoded request word |
| reqAddr | input | ADDR_W | Start address for fixed-length requests |
| extAddr | input | ADDR_W | Start address for variable-length requests |
| extLen | input | LEN_W | Byte length for variable-length requests |
| burstValid | output | 1 | Sub-burst issued, chip select may go low |
| burstAddr | output | ADDR_W | Sub-burst start address |
| burstLen | output | LEN_W | Sub-burst byte count |
| burstDone | input | 1 | Sub-burst finished |
| reqDone | output | 1 | Whole transfer finished (pulse) |

## Verification
Every result is tied to a fixed cycle. The first sub-burst appears two cycles after acceptance. `burstValid` falls at the edge that samples `burstDone`. The next sub-burst appears GAP_CLKS+1 cycles later, and `reqDone` is due in the cycle right after the final completion; for a zero length it is due in the cycle right after acceptance. The bench drives inputs on the falling edge and predicts, for each cycle, the full output set from the request fields and the budget formula. It compares that prediction against the design at every falling edge, so a result one cycle early or late is reported.

// File: rtl/req_split_pkg.sv
package req_split_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_ISSUE,
    ST_GAP,
    ST_DONE
  } splitState_t;

  typedef struct packed {
    logic load;     // capture decoded request
    logic latch;    // size the next sub-burst
    logic advance;  // step address and remaining count
  } dpStrb_t;

  localparam int SIZE_LSB   = 20;
  localparam int COUNT_LSB  = 24;
  localparam logic [3:0] VAR_CODE = 4'hF;

endpackage

// File: rtl/req_split_dp.sv
module req_split_dp
  import req_split_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 24,
  parameter int CSM_SHORT_US  = 4,
  parameter int CSM_LONG_US   = 8,
  parameter int OVH_CLKS      = 50,
  parameter int BYTES_PER_CLK = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [31:0]       reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [LEN_W-1:0]  extLen,
  input  logic [7:0]        cfgBusMhz,
  input  logic              cfgLongRefresh,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen,
  output logic              isZero,
  output logic              isLast
);

  logic [3:0]        sizeNib;
  logic [7:0]        countByte;
  logic [8:0]        countEff;
  logic              varMode;
  logic [LEN_W-1:0]  fixedTotal;
  logic [LEN_W-1:0]  totalLen;
  logic [ADDR_W-1:0] startAddr;
  logic [31:0]       windowClk;
  logic [31:0]       budgetWide;
  logic [LEN_W-1:0]  budget;
  logic [ADDR_W-1:0] addrReg;
  logic [LEN_W-1:0]  remReg;
  logic [LEN_W-1:0]  curLen;

  // request decode
  always_comb begin
    sizeNib    = reqWord[SIZE_LSB +: 4];
    countByte  = reqWord[COUNT_LSB +: 8];
    varMode    = (sizeNib == VAR_CODE);
    countEff   = (countByte == 8'd0) ? 9'd256 : {1'b0, countByte};
    fixedTotal = LEN_W'(countEff) << sizeNib;
    totalLen   = varMode ? extLen  : fixedTotal;
    startAddr  = varMode ? extAddr : reqAddr;
    isZero     = (totalLen == '0);
  end

  // chip-select byte budget
  always_comb begin
    windowClk = (cfgLongRefresh ? 32'(CSM_LONG_US) : 32'(CSM_SHORT_US)) * 32'(cfgBusMhz);
    if (windowClk > 32'(OVH_CLKS))
      budgetWide = (windowClk - 32'(OVH_CLKS)) * 32'(BYTES_PER_CLK);
    else
      budgetWide = 32'(BYTES_PER_CLK);
    budget = LEN_W'(budgetWide);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      remReg  <= '0;
      curLen  <= '0;
    end else begin
      if (strb.load) begin
        addrReg <= startAddr;
        remReg  <= totalLen;
      end
      if (strb.latch)
        curLen <= (remReg < budget) ? remReg : budget;
      if (strb.advance) begin
        addrReg <= addrReg + ADDR_W'(curLen);
        remReg  <= remReg - curLen;
      end
    end
  end

  assign burstAddr = addrReg;
  assign burstLen  = curLen;
  assign isLast    = (remReg == curLen);

  p_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> addrReg == $past(addrReg) + ADDR_W'($past(curLen)));

  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |=> (curLen != '0) && (curLen <= $past(budget)) && (curLen <= $past(remReg)));

  p_rem_down_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> remReg == $past(remReg) - $past(curLen));

endmodule

// File: rtl/req_split_ctrl.sv
module req_split_ctrl
  import req_split_pkg::*;
#(
  parameter int GAP_CLKS = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    burstDone,
  input  logic    isZero,
  input  logic    isLast,
  output logic    reqReady,
  output logic    burstValid,
  output logic    reqDone,
  output dpStrb_t strb
);

  localparam int GW = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS + 1);

  splitState_t state, nextState;
  logic [GW-1:0] gapCnt;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        nextState = isZero ? ST_DONE : ST_PREP;
      end
      ST_PREP: begin
        strb.latch = 1'b1;
        nextState  = ST_ISSUE;
      end
      ST_ISSUE: if (burstDone) begin
        strb.advance = 1'b1;
        nextState    = isLast ? ST_DONE : ST_GAP;
      end
      ST_GAP:  if (gapCnt == '0) nextState = ST_PREP;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      gapCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_ISSUE && nextState == ST_GAP)
        gapCnt <= GW'(GAP_CLKS - 1);
      else if (state == ST_GAP && gapCnt != '0)
        gapCnt <= gapCnt - 1'b1;
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign burstValid = (state == ST_ISSUE);
  assign reqDone    = (state == ST_DONE);

  p_ready_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(reqReady && burstValid));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone && reqReady);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && !burstDone |=> burstValid);

  p_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && burstDone |=> !burstValid);

  p_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstValid) && !reqDone |=> !burstValid);

endmodule

// File: rtl/req_split_top.sv
module req_split_top
  import req_split_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 24,
  parameter int CSM_SHORT_US  = 4,
  parameter int CSM_LONG_US   = 8,
  parameter int OVH_CLKS      = 50,
  parameter int BYTES_PER_CLK = 2,
  parameter int GAP_CLKS      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        cfgBusMhz,
  input  logic              cfgLongRefresh,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [31:0]       reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [LEN_W-1:0]  extLen,
  output logic              burstValid,
  output logic [ADDR_W-1:0] burstAddr,
  output logic [LEN_W-1:0]  burstLen,
  input  logic              burstDone,
  output logic              reqDone
);

  dpStrb_t strb;
  logic    isZero;
  logic    isLast;

  req_split_ctrl #(.GAP_CLKS(GAP_CLKS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .burstDone(burstDone),
    .isZero(isZero), .isLast(isLast), .reqReady(reqReady),
    .burstValid(burstValid), .reqDone(reqDone), .strb(strb)
  );

  req_split_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CSM_SHORT_US(CSM_SHORT_US),
    .CSM_LONG_US(CSM_LONG_US), .OVH_CLKS(OVH_CLKS), .BYTES_PER_CLK(BYTES_PER_CLK)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWord(reqWord), .reqAddr(reqAddr),
    .extAddr(extAddr), .extLen(extLen), .cfgBusMhz(cfgBusMhz),
    .cfgLongRefresh(cfgLongRefresh), .burstAddr(burstAddr), .burstLen(burstLen),
    .isZero(isZero), .isLast(isLast)
  );

  p_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    burstValid && !burstDone |=> $stable(burstAddr) && $stable(burstLen));

  p_len_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |-> burstLen != '0);

endmodule

// File: tb/tb_req_split_top.sv
module tb_req_split_top;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgBusMhz = 8'd100;
  logic        cfgLongRefresh = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqWord = '0;
  logic [31:0] reqAddr = '0;
  logic [31:0] extAddr = '0;
  logic [23:0] extLen = '0;
  logic        burstValid;
  logic [31:0] burstAddr;
  logic [23:0] burstLen;
  logic        burstDone = 1'b0;
  logic        reqDone;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  req_split_top dut (
    .clk(clk), .rstN(rstN), .cfgBusMhz(cfgBusMhz), .cfgLongRefresh(cfgLongRefresh),
    .reqValid(reqValid), .reqReady(reqReady), .reqWord(reqWord), .reqAddr(reqAddr),
    .extAddr(extAddr), .extLen(extLen), .burstValid(burstValid), .burstAddr(burstAddr),
    .burstLen(burstLen), .burstDone(burstDone), .reqDone(reqDone)
  );

  task automatic checkAll(input bit eV, input logic [31:0] eA, input int eL,
                          input bit eD, input bit eR, input string tag);
    bit bad;
    checks++;
    bad = (burstValid !== eV) || (reqDone !== eD) || (reqReady !== eR);
    if (eV && ((burstAddr !== eA) || (int'(burstLen) !== eL))) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%0b a=%h l=%0d d=%0b r=%0b exp v=%0b a=%h l=%0d d=%0b r=%0b",
               tag, burstValid, burstAddr, burstLen, reqDone, reqReady,
               eV, eA, eL, eD, eR);
    end
  endtask

  function automatic int budgetOf(input int mhz, input bit lng);
    int w;
    w = (lng ? 8 : 4) * mhz;
    return (w > 50) ? (w - 50) * 2 : 2;
  endfunction

  // Reference: one full request, predicted and compared on every cycle.
  task automatic doReq(input logic [31:0] word, input logic [31:0] a,
                       input logic [31:0] ea, input int el, input int mhz,
                       input bit lng, input int ack, input string tag);
    int total, cnt, rem, len, bud;
    logic [31:0] addr;
    if (word[23:20] == 4'd15) begin
      total = el; addr = ea;
    end else begin
      cnt = int'(word[31:24]);
      if (cnt == 0) cnt = 256;
      total = cnt << word[23:20];
      addr = a;
    end
    bud = budgetOf(mhz, lng);
    cfgBusMhz = 8'(mhz); cfgLongRefresh = lng;
    reqWord = word; reqAddr = a; extAddr = ea; extLen = 24'(el);
    reqValid = 1'b1;
    checkAll(0, 0, 0, 0, 1, "R10 idle ready");
    @(negedge clk);
    reqValid = 1'b0;
    if (total == 0) begin
      checkAll(0, 0, 0, 1, 0, "R5 zero length done");
      @(negedge clk);
      checkAll(0, 0, 0, 0, 1, "R5 back to idle");
      return;
    end
    checkAll(0, 0, 0, 0, 0, "R8 prep cycle");
    rem = total;
    while (rem > 0) begin
      len = (rem < bud) ? rem : bud;
      for (int c = 0; c < ack; c++) begin
        @(negedge clk);
        checkAll(1, addr, len, 0, 0, tag);
        burstDone = (c == ack - 1);
      end
      @(negedge clk);
      burstDone = 1'b0;
      rem -= len;
      addr += 32'(len);
      if (rem == 0) begin
        checkAll(0, 0, 0, 1, 0, "R10 done pulse");
        @(negedge clk);
        checkAll(0, 0, 0, 0, 1, "R10 idle after done");
      end else begin
        checkAll(0, 0, 0, 0, 0, "R9 gap");
        for (int g = 0; g < GAP; g++) begin
          @(negedge clk);
          checkAll(0, 0, 0, 0, 0, "R9 gap");
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkAll(0, 0, 0, 0, 1, "R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll(0, 0, 0, 0, 1, "R1 after reset");
    // R2 R6 R7: 100 blocks of 16 bytes, 100 MHz short window -> 700,700,200
    doReq(32'h6440_0000, 32'h0000_2000, 32'h0, 0, 100, 0, 3, "R2 R6 R7 fixed short");
    // R6 long window -> 1500,100
    doReq(32'h6440_0000, 32'h0000_8000, 32'h0, 0, 100, 1, 1, "R6 R7 long window");
    // R3 count zero, size 2 -> 1024 bytes -> 700,324
    doReq(32'h0020_0000, 32'h0001_0000, 32'h0, 0, 100, 0, 2, "R3 count zero");
    // R4 variable, count byte ignored, 20 MHz -> budget 60 -> 60,60,10
    doReq(32'h55F0_0000, 32'h0000_4000, 32'h1000_0000, 130, 20, 0, 2, "R4 variable");
    // R5 variable zero length
    doReq(32'h00F0_0000, 32'h0, 32'h2000_0000, 0, 100, 0, 1, "R5");
    // R6 budget floor at 10 MHz -> 2,2,1
    doReq(32'h0500_0000, 32'h0000_0100, 32'h0, 0, 10, 0, 1, "R6 floor budget");
    // R6 exact multiple -> 700,700
    doReq(32'h00F0_0000, 32'h0, 32'h0300_0000, 1400, 100, 0, 1, "R6 exact multiple");
    // R2 R7 largest block size, long window, address wrap region
    doReq(32'h01E0_0000, 32'hFFFF_E000, 32'h0, 0, 100, 1, 1, "R2 R7 size 14");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule